// File: doc/BRIEF.md
# Selectable-Threshold Hysteresis Comparator

This block makes an above/below decision on one digitized input channel. On each accepted beat it compares the chosen channel against a threshold. The threshold can come from one of two sources. It can be a programmable fraction of a full-scale supply code, or it can be the sample on one of two channels used as an external reference. An optional hysteresis band puts one trip level above the threshold and one below it, so a noisy input near the threshold does not make the decision toggle.

Samples for all channels arrive together as one beat on a valid/ready stream. The comparator never applies back-pressure. `in_ready` is high whenever reset is released, so every cycle with `in_valid` high consumes exactly one beat. The decision is a registered level output. It changes only at the clock edge that consumes a beat.

Configuration is held in a small register. It loads from the `cfg_*` pins in any cycle where `cfg_we` is high. The new settings apply to beats consumed from the next cycle on.

Top module: `thresh_cmp_top`

## Requirements
- R1: Reset leaves the configuration at input channel 0, reference code 4 (5/8 of full scale), external channel 0 and hysteresis off. A pulse on `cfg_we` loads all four fields at that clock edge.
- R2: Reference codes 0 to 6 set the threshold to floor(full_scale*(code+1)/8).
- R3: Reference codes 8 to 15 set the threshold to floor(full_scale*k/16), where k is 1, 3, 5, 7, 9, 11, 13, 15 for codes 8, 9, 10 to 15 in turn.
- R4: Reference code 7 uses a channel sample as the threshold: channel 0 when the external select bit is 0, channel 1 when it is 1.
- R5: The input select (SEL_W bits) picks the channel with that index. Channel i occupies bits [i*W +: W] of `in_data`.
- R6: With hysteresis off, a consumed beat sets `above` to 1 when the input is strictly greater than the threshold, and to 0 otherwise (including when they are equal).
- R7: With hysteresis on and `above` at 0, `above` becomes 1 only when the input is strictly greater than the threshold plus HYST_BAND/2.
- R8: With hysteresis on and `above` at 1, `above` becomes 0 only when the input is strictly less than the threshold minus HYST_BAND/2.
- R9: The upper trip level saturates at 2^W-1, and the lower trip level saturates at 0. Neither wraps around.
- R10: `above` resets to 0. It changes only on the edge that consumes a beat. `in_ready` is 1 whenever reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the configuration register |
| cfg_in_sel | input | SEL_W | Input channel index |
| cfg_ref_sel | input | 4 | Reference code |
| cfg_ext_sel | input | 1 | External reference channel (0 or 1) |
| cfg_hyst_en | input | 1 | Hysteresis enable |
| full_scale | input | W | Full-scale supply code |
| in_valid | input | 1 | Sample beat valid |
| in_ready | output | 1 | Beat accepted (always 1 out of reset) |
| in_data | input | NUM_CH*W | All channel samples, channel 0 in the low bits |
| above | output | 1 | Registered decision |

## Verification
The bench tests the exact-equality point for every fraction code. A design that used >= instead of > would report 1 where 0 is expected. The hysteresis scenario places the input exactly on each trip level and one code beyond it. A band that was off by one, or a comparison that was inclusive, would switch at the wrong code. The saturation scenario puts the threshold within half a band of each end of the code range. Trip levels that wrapped around would switch at once instead of holding the decision. A hold test changes the input while `in_valid` is low, which catches a decision register that updates on every cycle.

// File: rtl/thresh_cmp_pkg.sv
package thresh_cmp_pkg;
  localparam int REF_W = 4;
  localparam logic [REF_W-1:0] REF_SEL_RST = 4'd4;
  localparam logic [REF_W-1:0] REF_SEL_EXT = 4'd7;

  typedef struct packed {
    logic [REF_W-1:0] ref_sel;
    logic             ext_sel;
    logic             hyst_en;
  } cmp_cfg_t;

  localparam cmp_cfg_t CFG_RST = '{ref_sel: REF_SEL_RST, ext_sel: 1'b0, hyst_en: 1'b0};
endpackage

// File: rtl/cmp_ref_gen.sv
module cmp_ref_gen
  import thresh_cmp_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [REF_W-1:0] ref_sel,
  input  logic [W-1:0]     full_scale,
  input  logic [W-1:0]     ext_sample,
  output logic [W-1:0]     ref_lvl
);
  localparam int PW = W + REF_W;

  logic [REF_W-1:0] sixteenths;
  logic [PW-1:0]    fs_wide;
  logic [PW-1:0]    product;

  // numerator over 16: eighths become even sixteenths, upper codes odd ones
  always_comb begin
    if (ref_sel[3]) sixteenths = {ref_sel[2:0], 1'b1};
    else            sixteenths = {ref_sel[2:0], 1'b0} + 4'd2;
  end

  assign fs_wide = {{REF_W{1'b0}}, full_scale};
  assign product = fs_wide * {{W{1'b0}}, sixteenths};

  always_comb begin
    if (ref_sel == REF_SEL_EXT) ref_lvl = ext_sample;
    else                        ref_lvl = W'(product >> 4);
  end
endmodule

// File: rtl/cmp_trip_levels.sv
module cmp_trip_levels #(
  parameter int W         = 10,
  parameter int HYST_BAND = 16
) (
  input  logic [W-1:0] ref_lvl,
  output logic [W-1:0] hi_lvl,
  output logic [W-1:0] lo_lvl
);
  localparam logic [W-1:0] HALF     = W'(HYST_BAND / 2);
  localparam logic [W:0]   CODE_MAX = {1'b0, {W{1'b1}}};

  logic [W:0] hi_sum;

  assign hi_sum = {1'b0, ref_lvl} + {1'b0, HALF};

  always_comb begin
    if (hi_sum > CODE_MAX) hi_lvl = {W{1'b1}};
    else                   hi_lvl = hi_sum[W-1:0];
    if (ref_lvl >= HALF)   lo_lvl = ref_lvl - HALF;
    else                   lo_lvl = '0;
  end
endmodule

// File: rtl/cmp_decide.sv
module cmp_decide #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         hyst_en,
  input  logic [W-1:0] sample,
  input  logic [W-1:0] ref_lvl,
  input  logic [W-1:0] hi_lvl,
  input  logic [W-1:0] lo_lvl,
  output logic         above
);
  logic above_nxt;

  always_comb begin
    above_nxt = above;
    if (!hyst_en)              above_nxt = (sample > ref_lvl);
    else if (!above)           above_nxt = (sample > hi_lvl);
    else                       above_nxt = !(sample < lo_lvl);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    above <= 1'b0;
    else if (take) above <= above_nxt;
  end
endmodule

// File: rtl/thresh_cmp_top.sv
module thresh_cmp_top
  import thresh_cmp_pkg::*;
#(
  parameter int W         = 10,
  parameter int NUM_CH    = 8,
  parameter int HYST_BAND = 16,
  parameter int SEL_W     = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_in_sel,
  input  logic [REF_W-1:0]    cfg_ref_sel,
  input  logic                cfg_ext_sel,
  input  logic                cfg_hyst_en,
  input  logic [W-1:0]        full_scale,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [NUM_CH*W-1:0] in_data,
  output logic                above
);
  cmp_cfg_t         cfg_q;
  logic [SEL_W-1:0] in_sel_q;
  logic [W-1:0]     chan [NUM_CH];
  logic [W-1:0]     sel_sample;
  logic [W-1:0]     ext_sample;
  logic [W-1:0]     ref_lvl;
  logic [W-1:0]     hi_lvl;
  logic [W-1:0]     lo_lvl;
  logic             hyst_on;
  logic             take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= CFG_RST;
      in_sel_q <= '0;
    end else if (cfg_we) begin
      cfg_q    <= '{ref_sel: cfg_ref_sel, ext_sel: cfg_ext_sel, hyst_en: cfg_hyst_en};
      in_sel_q <= cfg_in_sel;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_unpack
    assign chan[i] = in_data[i*W +: W];
  end

  assign sel_sample = chan[in_sel_q];
  assign ext_sample = cfg_q.ext_sel ? chan[1] : chan[0];
  assign hyst_on    = cfg_q.hyst_en;
  assign in_ready   = rst_n;
  assign take       = in_valid && in_ready;

  cmp_ref_gen #(.W(W)) u_ref (
    .ref_sel    (cfg_q.ref_sel),
    .full_scale (full_scale),
    .ext_sample (ext_sample),
    .ref_lvl    (ref_lvl)
  );

  cmp_trip_levels #(.W(W), .HYST_BAND(HYST_BAND)) u_trip (
    .ref_lvl (ref_lvl),
    .hi_lvl  (hi_lvl),
    .lo_lvl  (lo_lvl)
  );

  cmp_decide #(.W(W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .hyst_en (hyst_on),
    .sample  (sel_sample),
    .ref_lvl (ref_lvl),
    .hi_lvl  (hi_lvl),
    .lo_lvl  (lo_lvl),
    .above   (above)
  );
endmodule

// File: rtl/thresh_cmp_chk.sv
module thresh_cmp_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         hyst_on,
  input logic [W-1:0] sample,
  input logic [W-1:0] ref_lvl,
  input logic [W-1:0] hi_lvl,
  input logic [W-1:0] lo_lvl,
  input logic         above
);
  // R10
  hold_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(above));

  // R10
  ready_out_of_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);

  // R6
  plain_compare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !hyst_on) |=> (above == ($past(sample) > $past(ref_lvl))));

  // R7
  no_early_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hyst_on && !above && sample <= hi_lvl) |=> !above);

  // R8
  no_early_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hyst_on && above && sample >= lo_lvl) |=> above);

  // R9
  trip_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_lvl >= ref_lvl) && (lo_lvl <= ref_lvl));
endmodule

bind thresh_cmp_top thresh_cmp_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .hyst_on  (hyst_on),
  .sample   (sel_sample),
  .ref_lvl  (ref_lvl),
  .hi_lvl   (hi_lvl),
  .lo_lvl   (lo_lvl),
  .above    (above)
);

// File: tb/thresh_cmp_top_test.sv
module thresh_cmp_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 10;
  localparam int NCH        = 8;
  localparam int HB         = 16;
  localparam int HALF       = HB / 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [2:0]      cfg_in_sel = '0;
  logic [3:0]      cfg_ref_sel = '0;
  logic            cfg_ext_sel = 1'b0;
  logic            cfg_hyst_en = 1'b0;
  logic [W-1:0]    full_scale = 10'd800;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [NCH*W-1:0] in_data;
  logic            above;
  logic [W-1:0]    ch [NCH];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign in_data = {ch[7], ch[6], ch[5], ch[4], ch[3], ch[2], ch[1], ch[0]};

  thresh_cmp_top #(.W(W), .NUM_CH(NCH), .HYST_BAND(HB)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_in_sel(cfg_in_sel),
    .cfg_ref_sel(cfg_ref_sel), .cfg_ext_sel(cfg_ext_sel), .cfg_hyst_en(cfg_hyst_en),
    .full_scale(full_scale), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .above(above)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_of(input int code, input int fs, input int ext);
    if (code < 7)       return fs * (code + 1) / 8;
    else if (code == 7) return ext;
    else                return fs * (2 * (code - 8) + 1) / 16;
  endfunction

  task automatic set_cfg(input int sel, input int rsel, input bit ext, input bit hyst);
    @(negedge clk);
    cfg_in_sel = 3'(sel); cfg_ref_sel = 4'(rsel);
    cfg_ext_sel = ext; cfg_hyst_en = hyst; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one beat on the chosen channel; result read at the following negedge
  task automatic beat(input int sel, input int val);
    @(negedge clk);
    ch[sel] = W'(val);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R10 reset above", int'(above), 0);
    check("R10 ready", int'(in_ready), 1);
    beat(0, 501);
    check("R1 default 5/8 ref above", int'(above), 1);
    beat(0, 500);
    check("R1 R6 default ref equal", int'(above), 0);
  endtask

  task automatic t_eighths;
    for (int c = 0; c < 7; c++) begin
      int r;
      r = ref_of(c, 800, 0);
      set_cfg(0, c, 1'b0, 1'b0);
      beat(0, r + 1);
      check($sformatf("R2 code %0d above", c), int'(above), 1);
      beat(0, r);
      check($sformatf("R2 R6 code %0d equal", c), int'(above), 0);
    end
  endtask

  task automatic t_sixteenths;
    full_scale = 10'd1023;
    for (int c = 8; c < 16; c++) begin
      int r;
      r = ref_of(c, 1023, 0);
      set_cfg(0, c, 1'b0, 1'b0);
      beat(0, r + 1);
      check($sformatf("R3 code %0d above", c), int'(above), 1);
      beat(0, r);
      check($sformatf("R3 code %0d equal", c), int'(above), 0);
    end
    full_scale = 10'd800;
  endtask

  task automatic t_ext;
    ch[1] = 10'd400;
    ch[0] = 10'd300;
    set_cfg(3, 7, 1'b0, 1'b0);
    beat(3, 301);
    check("R4 ext ch0 above", int'(above), 1);
    set_cfg(3, 7, 1'b1, 1'b0);
    beat(3, 301);
    check("R4 ext ch1 below", int'(above), 0);
    beat(3, 401);
    check("R4 ext ch1 above", int'(above), 1);
  endtask

  task automatic t_insel;
    for (int s = 0; s < NCH; s++) begin
      set_cfg(s, 4, 1'b0, 1'b0);
      for (int k = 0; k < NCH; k++) ch[k] = 10'd400;
      beat(s, 600);
      check($sformatf("R5 sel %0d high", s), int'(above), 1);
      for (int k = 0; k < NCH; k++) ch[k] = 10'd600;
      beat(s, 400);
      check($sformatf("R5 sel %0d low", s), int'(above), 0);
    end
  endtask

  task automatic t_hold;
    set_cfg(0, 4, 1'b0, 1'b0);
    beat(0, 700);
    @(negedge clk);
    ch[0] = 10'd10;
    repeat (3) @(negedge clk);
    check("R10 hold without beat", int'(above), 1);
    beat(0, 10);
    check("R10 update on beat", int'(above), 0);
  endtask

  task automatic t_hyst;
    set_cfg(0, 4, 1'b0, 1'b1);
    beat(0, 0);
    check("R7 start low", int'(above), 0);
    beat(0, 500 + HALF);
    check("R7 at upper trip", int'(above), 0);
    beat(0, 500 + HALF + 1);
    check("R7 past upper trip", int'(above), 1);
    beat(0, 495);
    check("R8 inside band", int'(above), 1);
    beat(0, 500 - HALF);
    check("R8 at lower trip", int'(above), 1);
    beat(0, 500 - HALF - 1);
    check("R8 past lower trip", int'(above), 0);
  endtask

  task automatic t_sat;
    ch[0] = 10'd1020;
    set_cfg(3, 7, 1'b0, 1'b1);
    beat(3, 0);
    check("R9 high end start low", int'(above), 0);
    beat(3, 1023);
    check("R9 upper trip saturated", int'(above), 0);
    ch[0] = 10'd3;
    beat(3, 1023);
    check("R9 low end rise", int'(above), 1);
    beat(3, 0);
    check("R9 lower trip saturated", int'(above), 1);
  endtask

  initial begin
    for (int k = 0; k < NCH; k++) ch[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_eighths();
    t_sixteenths();
    t_ext();
    t_insel();
    t_hold();
    t_hyst();
    t_sat();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule